// File: doc/BRIEF.md
# Presettable Bi-Quinary Decade Counter

This block is a four-bit decade counter made of two stages. One stage divides by two and drives the low output bit. The other divides by five and drives the upper three bits. Each stage has its own count input and advances when that input falls. A mode pin selects how the two stages are chained inside the block, so no external strap is needed. In BCD mode the external count drives the divide-by-two stage, and its falling output advances the divide-by-five stage. The output then runs through 0 to 9 in 8-4-2-1 weighting. In bi-quinary mode the external count drives the divide-by-five stage, and each wrap of that stage toggles the low bit. The low bit then becomes a divide-by-ten output with equal high and low times.

The whole block runs on one system clock. Both count inputs are sampled on that clock, and a falling edge is a registered sample of 1 followed by a current sample of 0. An active-low master reset clears the state at once. An active-low parallel load copies the four data inputs into the state on every clock while it is held, so the block can also serve as a transparent four-bit latch. The block has no data stream, so it has no valid/ready handshake. All of its pins are plain control and status lines.

Top module: `biquin_counter`

## Requirements
- R1: While `rst_n` is low, `cnt_q` is 0000 without waiting for a clock edge, whatever the load, data and count inputs do; reset takes priority over load and counting.
- R2: On every clock edge with `rst_n` high and `load_n` low, `cnt_q` takes the value of `load_d`, so changes on `load_d` appear one cycle later. Load takes priority over counting.
- R3: A count event is a clock edge where the previous sample of a count input was 1 and the current sample is 0. An input that stays low for several cycles gives one event only, and with no event the state does not change.
- R4: With `chain_biq` = 0 (BCD), each event on `tick_two` advances `cnt_q` through 0,1,...,9 and then back to 0. In this mode `tick_five` has no effect.
- R5: With `chain_biq` = 1 (bi-quinary), each event on `tick_five` steps the bits {cnt_q[0],cnt_q[3],cnt_q[2],cnt_q[1]} through 0000,0001,0010,0011,0100,1000,1001,1010,1011,1100 and then back to 0000. `cnt_q[0]` is high for exactly 5 of every 10 events. In this mode `tick_two` has no effect.
- R6: If the divide-by-five field cnt_q[3:1] holds 5, 6 or 7, its next advance sets it to 0. This counts as no wrap, so in bi-quinary mode cnt_q[0] is unchanged. In BCD mode, loading 1111 and then giving one event yields 0000.
- R7: A falling count input seen while reset or load is active causes no advance, neither then nor after the load is released.
- R8: Changing `chain_biq` does not change `cnt_q`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register is updated on its rising edge |
| rst_n | input | 1 | Asynchronous active-low master reset |
| load_n | input | 1 | Active-low parallel load |
| load_d | input | 4 | Parallel data; bit 0 goes to the divide-by-two stage, bits 3:1 to the divide-by-five stage |
| tick_two | input | 1 | Count input of the divide-by-two stage (falling edge) |
| tick_five | input | 1 | Count input of the divide-by-five stage (falling edge) |
| chain_biq | input | 1 | Chaining select: 0 = BCD, 1 = bi-quinary |
| cnt_q | output | 4 | Counter state; bit 0 is the divide-by-two output |

## Verification
Two pairs of functions can fall on the same clock edge: a falling count input together with an active load, and an active load together with an asserted reset. The bench provokes the first pair by dropping the count input in the middle of a load pulse. It then checks that the state equals the loaded data, both during the load and after release, with no late advance. It provokes the second pair by pulling reset low between clock edges while load is held low with nonzero data, and checks that the output reads zero before the next edge. Every cycle is also compared against a behavioural model that applies the priority reset, then load, then count.

// File: rtl/biquin_pkg.sv
package biquin_pkg;
  typedef enum logic {
    CHAIN_BCD = 1'b0,
    CHAIN_BIQ = 1'b1
  } chain_e;

  localparam int TICK_TWO_IDX  = 0;
  localparam int TICK_FIVE_IDX = 1;
  localparam int TICK_COUNT    = 2;
endpackage

// File: rtl/fall_sense.sv
module fall_sense #(
  parameter int WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sig_i,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  for (genvar i = 0; i < WIDTH; i++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q[i] <= 1'b0;
      else        prev_q[i] <= sig_i[i];
    end
    assign fall_o[i] = prev_q[i] & ~sig_i[i];
  end
endmodule

// File: rtl/toggle_stage.sv
module toggle_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_i,
  input  logic ld_val_i,
  input  logic adv_i,
  output logic bit_o,
  output logic at_top_o
);
  logic bit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bit_q <= 1'b0;
    else if (ld_i)  bit_q <= ld_val_i;
    else if (adv_i) bit_q <= ~bit_q;
  end

  assign bit_o    = bit_q;
  assign at_top_o = bit_q;

  // R3
  toggle_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i) |=> (bit_q != $past(bit_q)));
endmodule

// File: rtl/modn_stage.sv
module modn_stage #(
  parameter int MOD = 5,
  localparam int W = (MOD > 2) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         adv_i,
  output logic [W-1:0] val_o,
  output logic         at_top_o
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  logic [W-1:0] val_q;
  logic [W-1:0] val_next;

  always_comb begin
    if (val_q >= TOP) val_next = '0;
    else              val_next = val_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     val_q <= '0;
    else if (ld_i)  val_q <= ld_val_i;
    else if (adv_i) val_q <= val_next;
  end

  assign val_o    = val_q;
  assign at_top_o = (val_q == TOP);

  // R6
  modn_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv_i && !ld_i && val_q >= TOP) |=> (val_q == '0));
endmodule

// File: rtl/biquin_counter.sv
module biquin_counter #(
  parameter int FIVE_MOD = 5,
  localparam int FW = (FIVE_MOD > 2) ? $clog2(FIVE_MOD) : 1,
  localparam int QW = FW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_n,
  input  logic [QW-1:0] load_d,
  input  logic          tick_two,
  input  logic          tick_five,
  input  logic          chain_biq,
  output logic [QW-1:0] cnt_q
);
  import biquin_pkg::*;

  localparam logic [QW-1:0] BCD_LAST = {FW'(FIVE_MOD - 1), 1'b1};

  chain_e                chain;
  logic [TICK_COUNT-1:0] raw_ticks;
  logic [TICK_COUNT-1:0] falls;
  logic                  load_act;
  logic                  two_adv, five_adv;
  logic                  two_top, five_top;
  logic                  two_bit;
  logic [FW-1:0]         five_val;

  assign chain     = chain_e'(chain_biq);
  assign load_act  = ~load_n;
  assign raw_ticks[TICK_TWO_IDX]  = tick_two;
  assign raw_ticks[TICK_FIVE_IDX] = tick_five;

  fall_sense #(.WIDTH(TICK_COUNT)) u_sense (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_i  (raw_ticks),
    .fall_o (falls)
  );

  always_comb begin
    if (chain == CHAIN_BCD) begin
      two_adv  = falls[TICK_TWO_IDX];
      five_adv = falls[TICK_TWO_IDX] & two_top;
    end else begin
      five_adv = falls[TICK_FIVE_IDX];
      two_adv  = falls[TICK_FIVE_IDX] & five_top;
    end
  end

  toggle_stage u_two (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_act),
    .ld_val_i (load_d[0]),
    .adv_i    (two_adv),
    .bit_o    (two_bit),
    .at_top_o (two_top)
  );

  modn_stage #(.MOD(FIVE_MOD)) u_five (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_i     (load_act),
    .ld_val_i (load_d[QW-1:1]),
    .adv_i    (five_adv),
    .val_o    (five_val),
    .at_top_o (five_top)
  );

  assign cnt_q = {five_val, two_bit};

  // R2
  load_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> (cnt_q == $past(load_d)));

  // R4
  bcd_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && chain == CHAIN_BCD && falls[TICK_TWO_IDX] && cnt_q == BCD_LAST)
      |=> (cnt_q == '0));

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && falls == '0) |=> $stable(cnt_q));

  // R5
  biq_ignore_two_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && chain == CHAIN_BIQ && !falls[TICK_FIVE_IDX]) |=> $stable(cnt_q));
endmodule

// File: tb/biquin_counter_test.sv
module biquin_counter_test;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] load_d = 4'h0;
  logic       tick_two = 1'b0;
  logic       tick_five = 1'b0;
  logic       chain_biq = 1'b0;
  logic [3:0] cnt_q;

  int checks = 0;
  int errors = 0;
  int m_q0 = 0, m_five = 0, m_pa = 0, m_pb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  biquin_counter uut (
    .clk(clk), .rst_n(rst_n), .load_n(load_n), .load_d(load_d),
    .tick_two(tick_two), .tick_five(tick_five), .chain_biq(chain_biq),
    .cnt_q(cnt_q)
  );

  function automatic logic [3:0] model_val();
    return 4'((m_five << 1) | m_q0);
  endfunction

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, model at posedge, compare at next negedge
  task automatic step(bit r, bit ld, logic [3:0] d, bit a, bit b, bit m);
    bit ta, tb;
    string tag;
    rst_n = r; load_n = ld; load_d = d; tick_two = a; tick_five = b; chain_biq = m;
    @(posedge clk);
    if (!r) begin
      m_q0 = 0; m_five = 0; m_pa = 0; m_pb = 0;
    end else begin
      ta = (m_pa == 1) && !a;
      tb = (m_pb == 1) && !b;
      m_pa = a; m_pb = b;
      if (!ld) begin
        m_q0 = d[0]; m_five = int'(d[3:1]);
      end else if (!m) begin
        if (ta) begin
          if (m_q0 == 1) begin
            m_q0 = 0;
            m_five = (m_five >= 4) ? 0 : m_five + 1;
          end else m_q0 = 1;
        end
      end else if (tb) begin
        if (m_five == 4) begin m_five = 0; m_q0 = 1 - m_q0; end
        else if (m_five > 4) m_five = 0;
        else m_five = m_five + 1;
      end
    end
    @(negedge clk);
    tag = !r ? "R1" : (!ld ? "R2" : (m ? "R5" : "R4"));
    check(tag, cnt_q, model_val());
  endtask

  task automatic pulse_two(bit m);
    step(1, 1, 4'h0, 1, 0, m);
    step(1, 1, 4'h0, 0, 0, m);
  endtask

  task automatic pulse_five(bit m);
    step(1, 1, 4'h0, 0, 1, m);
    step(1, 1, 4'h0, 0, 0, m);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [3:0] seen;
    int highs;
    @(negedge clk);
    step(0, 1, 4'h0, 0, 0, 0);
    step(0, 0, 4'h9, 1, 1, 0);
    check("R1", cnt_q, 4'h0);

    // R4: BCD over two full cycles, tick_five wiggling
    step(1, 1, 4'h0, 0, 0, 0);
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 4'h0, 1, 1, 0);
      step(1, 1, 4'h0, 0, 0, 0);
      check("R4", cnt_q, 4'((i + 1) % 10));
    end

    // R3: held low gives one event only
    step(1, 1, 4'h0, 1, 0, 0);
    for (int i = 0; i < 4; i++) step(1, 1, 4'h0, 0, 0, 0);
    check("R3", cnt_q, 4'h1);

    // R8: mode flips without events keep state
    seen = cnt_q;
    step(1, 1, 4'h0, 0, 0, 1);
    step(1, 1, 4'h0, 0, 0, 0);
    step(1, 1, 4'h0, 0, 0, 1);
    check("R8", cnt_q, seen);

    // R5: bi-quinary, two full cycles, tick_two wiggling
    step(1, 0, 4'h0, 0, 0, 1);
    step(1, 1, 4'h0, 0, 0, 1);
    highs = 0;
    for (int i = 0; i < 20; i++) begin
      step(1, 1, 4'h0, 1, 1, 1);
      step(1, 1, 4'h0, 0, 0, 1);
      if (cnt_q[0]) highs++;
    end
    checks++;
    if (highs != 10) begin
      errors++;
      $display("FAIL R5 duty actual=%0d expected=10", highs);
    end
    check("R5", cnt_q, 4'h0);

    // R6: divide-by-five preloaded out of range
    step(1, 0, 4'b1100, 0, 0, 1);
    pulse_five(1);
    check("R6", cnt_q, 4'b0000);
    step(1, 0, 4'b1011, 0, 0, 1);
    pulse_five(1);
    check("R6", cnt_q, 4'b0001);
    step(1, 0, 4'b1111, 0, 0, 0);
    pulse_two(0);
    check("R6", cnt_q, 4'b0000);

    // R2: transparent latch behaviour
    step(1, 0, 4'h5, 0, 0, 0);
    check("R2", cnt_q, 4'h5);
    step(1, 0, 4'hA, 0, 0, 0);
    check("R2", cnt_q, 4'hA);

    // R7: falling count during load, then release
    step(1, 0, 4'h3, 1, 1, 0);
    step(1, 0, 4'h3, 0, 0, 0);
    step(1, 1, 4'h0, 0, 0, 0);
    step(1, 1, 4'h0, 0, 0, 0);
    check("R7", cnt_q, 4'h3);
    // R7: falling count during reset
    step(1, 1, 4'h0, 1, 0, 0);
    step(0, 1, 4'h0, 0, 0, 0);
    step(1, 1, 4'h0, 0, 0, 0);
    check("R7", cnt_q, 4'h0);

    // R1: asynchronous reset mid-cycle while load is held
    step(1, 0, 4'h7, 0, 0, 0);
    load_n = 1'b0; load_d = 4'h6;
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    #1;
    check("R1", cnt_q, 4'h0);
    @(negedge clk);
    check("R1", cnt_q, 4'h0);
    step(0, 1, 4'h0, 0, 0, 0);
    step(1, 1, 4'h0, 0, 0, 0);
    pulse_two(0);
    check("R4", cnt_q, 4'h1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule